// File: doc/BRIEF.md
# Expansion ROM Window Register and Decoder

This block is the device-side logic for an optional expansion ROM window on a PCI-style function. It holds the expansion ROM base register, serves it over a small configuration read/write port (dword offset, byte enables, write data, read data), and compares incoming 32-bit memory addresses against the programmed window. A hit is flagged when the address lies inside the window and decoding is permitted. The ROM storage, the rest of the configuration header, and I/O or 64-bit BARs live outside this block.

The ROM size is fixed at build time as a power of two, from 2 KB upward. The window is naturally aligned to that size. Only the base bits at or above the size boundary can be written, so software can find the size by writing all ones to bits 31:11 and reading the register back. Bit 0 is a separate decode enable. The memory-space enable bit of the command register comes in from outside. A parameter places the register at the normal header position or the bridge header position. A second parameter builds the register with no ROM, and then it is all zeros.

Top module: `xrom_window_dec`

## Requirements
- R1: After reset the register reads 0, with the base and the enable bit cleared, so no address is claimed until software programs it.
- R2: With the default 128 KB size, writing FFFF_F800h reads back FFFE_0000h. In general, bits 31 down to the size boundary are writable and all lower base bits read 0, so the size is ~readback + 1 with bit 0 masked off.
- R3: Bits 10:1, and the base bits below the size boundary, always read 0 and ignore writes.
- R4: On a write, byte enable bit n selects data bits 8n+7:8n. Lanes that are not selected keep their contents.
- R5: Bit 0 is a read/write decode enable. When it is 0, no address is claimed.
- R6: rom_hit_o is 1 only when mem_valid_i, the enable bit and mem_space_en_i are all 1, and the address lies in the window.
- R7: The window is [base, base + size - 1], with base aligned to the size. Only the address bits at or above the size boundary are compared, so the last byte of the window hits and the bytes just outside it miss.
- R8: The register sits at dword offset 0Ch (byte 30h) in a normal header build and at 0Eh (byte 38h) in a bridge header build. Writes to any other offset leave it unchanged, and reads at other offsets return 0.
- R9: A build with no ROM reads 0 at its offset, ignores writes, and never asserts a hit.
- R10: rom_hit_o is combinational from the address and the stored register, so it is valid in the same cycle as mem_valid_i.
- R11: cfg_rdata_o is combinational, and equals the register when cfg_req_i=1, cfg_we_i=0 and the offset matches, otherwise 0. A write takes effect at the clock edge on which it is presented, so it is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Configuration access strobe |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_dw_off_i | input | 6 | Configuration dword offset |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data (0 when not selected) |
| mem_space_en_i | input | 1 | Memory-space enable from the command register |
| mem_valid_i | input | 1 | Memory address strobe |
| mem_addr_i | input | 32 | Memory address |
| rom_hit_o | output | 1 | Address claimed by the ROM window |

## Verification
Both outputs are due with no delay. Read data and the hit flag follow their inputs in the same cycle, and a configuration write first changes them in the cycle after the edge that captured it. The bench drives on the falling edge and compares all outputs one nanosecond later against a behavioural model, on every clock. The model commits writes at the rising edge, so it stays aligned with that one-edge latency. Directed reads and address probes are sampled at the same point, inside the cycle they are driven. The default, bridge and no-ROM builds run side by side on shared inputs.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned CFG_OFF_W = 6;
  localparam logic [CFG_OFF_W-1:0] OFF_ENDPOINT = 6'h0C;
  localparam logic [CFG_OFF_W-1:0] OFF_BRIDGE   = 6'h0E;

  // window compare mask: bits at/above the size boundary
  function automatic logic [ADDR_W-1:0] win_mask(int unsigned sz_log2);
    return {ADDR_W{1'b1}} << sz_log2;
  endfunction

  // writable bits: base field plus enable bit
  function automatic logic [ADDR_W-1:0] wr_mask(int unsigned sz_log2);
    return win_mask(sz_log2) | {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/xrom_cfg_sel.sv
module xrom_cfg_sel
  import xrom_pkg::*;
#(
  parameter bit BRIDGE_HDR = 1'b0
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [CFG_OFF_W-1:0] off_i,
  output logic                 wr_o,
  output logic                 rd_o
);
  localparam logic [CFG_OFF_W-1:0] MY_OFF = BRIDGE_HDR ? OFF_BRIDGE : OFF_ENDPOINT;

  logic match;
  assign match = (off_i == MY_OFF);
  assign wr_o  = req_i & we_i & match;
  assign rd_o  = req_i & ~we_i & match;
endmodule

// File: rtl/xrom_bar_reg.sv
module xrom_bar_reg
  import xrom_pkg::*;
#(
  parameter bit          ROM_PRESENT   = 1'b1,
  parameter int unsigned ROM_SIZE_LOG2 = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [3:0]        be_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] bar_o,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int unsigned  LANES = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] WMASK = ROM_PRESENT ? wr_mask(ROM_SIZE_LOG2) : '0;

  logic [7:0] lane_q [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (ROM_PRESENT) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          lane_q[l] <= '0;
        else if (wr_i && be_i[l])
          lane_q[l] <= wdata_i[8*l +: 8] & WMASK[8*l +: 8];
      end

      assert_lane_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !be_i[l]) |=> $stable(lane_q[l]));
    end else begin : g_tie
      assign lane_q[l] = '0;
    end
    assign bar_o[8*l +: 8] = lane_q[l];
  end

  assign rdata_o = rd_i ? bar_o : '0;

  if (ROM_PRESENT) begin : g_chk
    assert_en_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && be_i[0]) |=> (bar_o[0] == $past(wdata_i[0])));
    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(bar_o));
    assert_low_bits_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bar_o & ~WMASK) == '0);
  end
endmodule

// File: rtl/xrom_addr_cmp.sv
module xrom_addr_cmp
  import xrom_pkg::*;
#(
  parameter bit          ROM_PRESENT   = 1'b1,
  parameter int unsigned ROM_SIZE_LOG2 = 17
) (
  input  logic              valid_i,
  input  logic              mse_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] bar_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] WIN = win_mask(ROM_SIZE_LOG2);

  if (ROM_PRESENT) begin : g_cmp
    logic in_win;
    assign in_win = ((addr_i ^ bar_i) & WIN) == '0;
    assign hit_o  = valid_i & mse_i & bar_i[0] & in_win;
  end else begin : g_none
    logic unused;
    assign unused = valid_i ^ mse_i ^ (^addr_i) ^ (^bar_i);
    assign hit_o  = 1'b0;
  end
endmodule

// File: rtl/xrom_window_dec.sv
module xrom_window_dec
  import xrom_pkg::*;
#(
  parameter bit          ROM_PRESENT   = 1'b1,
  parameter bit          BRIDGE_HDR    = 1'b0,
  parameter int unsigned ROM_SIZE_LOG2 = 17
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_req_i,
  input  logic                 cfg_we_i,
  input  logic [CFG_OFF_W-1:0] cfg_dw_off_i,
  input  logic [3:0]           cfg_be_i,
  input  logic [ADDR_W-1:0]    cfg_wdata_i,
  output logic [ADDR_W-1:0]    cfg_rdata_o,
  input  logic                 mem_space_en_i,
  input  logic                 mem_valid_i,
  input  logic [ADDR_W-1:0]    mem_addr_i,
  output logic                 rom_hit_o
);
  localparam logic [CFG_OFF_W-1:0] MY_OFF = BRIDGE_HDR ? OFF_BRIDGE : OFF_ENDPOINT;

  logic              wr_sel, rd_sel;
  logic [ADDR_W-1:0] bar;

  xrom_cfg_sel #(.BRIDGE_HDR(BRIDGE_HDR)) i_sel (
    .req_i (cfg_req_i),
    .we_i  (cfg_we_i),
    .off_i (cfg_dw_off_i),
    .wr_o  (wr_sel),
    .rd_o  (rd_sel)
  );

  xrom_bar_reg #(.ROM_PRESENT(ROM_PRESENT), .ROM_SIZE_LOG2(ROM_SIZE_LOG2)) i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel),
    .rd_i    (rd_sel),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .bar_o   (bar),
    .rdata_o (cfg_rdata_o)
  );

  xrom_addr_cmp #(.ROM_PRESENT(ROM_PRESENT), .ROM_SIZE_LOG2(ROM_SIZE_LOG2)) i_cmp (
    .valid_i (mem_valid_i),
    .mse_i   (mem_space_en_i),
    .addr_i  (mem_addr_i),
    .bar_i   (bar),
    .hit_o   (rom_hit_o)
  );

  assert_hit_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_hit_o |-> (mem_valid_i && mem_space_en_i && bar[0]));
  assert_other_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_dw_off_i != MY_OFF) |-> (cfg_rdata_o == '0));
  assert_enable_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_we_i && cfg_dw_off_i == MY_OFF && cfg_be_i[0] && !cfg_wdata_i[0])
      |=> !rom_hit_o);

  if (!ROM_PRESENT) begin : g_norom_chk
    assert_norom_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rom_hit_o && cfg_rdata_o == '0);
  end
endmodule

// File: tb/test_xrom_window_dec.sv
`timescale 1ns/100ps
module test_xrom_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, mse = 1'b0, mvalid = 1'b0;
  logic [5:0]  off = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, maddr = '0;
  logic [31:0] rdata [3];
  logic        hit [3];

  int n_tests = 0, n_fail = 0;
  int cycles = 0;

  // instance table: 0 = endpoint 128 KB, 1 = bridge 4 KB, 2 = no ROM
  int unsigned m_off [3] = '{12, 14, 12};
  int unsigned m_sz  [3] = '{17, 12, 17};
  bit          m_pres[3] = '{1'b1, 1'b1, 1'b0};
  longint unsigned m_bar [3];

  always #2.5 clk = ~clk;

  xrom_window_dec i_xrom_window_dec (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we), .cfg_dw_off_i(off),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata[0]), .mem_space_en_i(mse),
    .mem_valid_i(mvalid), .mem_addr_i(maddr), .rom_hit_o(hit[0]));

  xrom_window_dec #(.BRIDGE_HDR(1'b1), .ROM_SIZE_LOG2(12)) i_bridge (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we), .cfg_dw_off_i(off),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata[1]), .mem_space_en_i(mse),
    .mem_valid_i(mvalid), .mem_addr_i(maddr), .rom_hit_o(hit[1]));

  xrom_window_dec #(.ROM_PRESENT(1'b0)) i_norom (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we), .cfg_dw_off_i(off),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata[2]), .mem_space_en_i(mse),
    .mem_valid_i(mvalid), .mem_addr_i(maddr), .rom_hit_o(hit[2]));

  function automatic longint unsigned size_of(int k);
    return longint'(1) << m_sz[k];
  endfunction

  // reference model: commits writes at the rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) m_bar[k] <= 0;
    end else if (req && we) begin
      for (int k = 0; k < 3; k++) begin
        if (m_pres[k] && off == m_off[k]) begin
          longint unsigned v;
          v = m_bar[k];
          for (int b = 0; b < 32; b++) begin
            if (be[b/8] && (b == 0 || b >= m_sz[k])) v[b] = wdata[b];
          end
          m_bar[k] <= v;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rdata(int k);
    return (req && !we && off == m_off[k]) ? m_bar[k][31:0] : 32'h0;
  endfunction

  function automatic logic exp_hit(int k);
    longint unsigned base;
    base = m_bar[k] - (m_bar[k] % size_of(k));
    return m_pres[k] && mvalid && mse && m_bar[k][0] &&
           (maddr >= base) && (maddr < base + size_of(k));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R10, R11 timing)
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int k = 0; k < 3; k++) begin
        chk($sformatf("R11 model rdata inst %0d", k), rdata[k], exp_rdata(k));
        chk($sformatf("R10 model hit inst %0d", k), {31'b0, hit[k]}, {31'b0, exp_hit(k)});
      end
    end
  end

  task automatic cfg_wr(logic [5:0] o, logic [3:0] e, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; off = o; be = e; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic cfg_rd(logic [5:0] o);
    @(negedge clk);
    req = 1'b1; we = 1'b0; off = o;
    #1;
  endtask

  task automatic probe(logic v, logic m, logic [31:0] a);
    @(negedge clk);
    req = 1'b0; mvalid = v; mse = m; maddr = a;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_rd(6'h0C); chk("R1 reset read ep", rdata[0], 32'h0);
    cfg_rd(6'h0E); chk("R1 reset read bridge", rdata[1], 32'h0);
    probe(1'b1, 1'b1, 32'h0); chk("R1 no hit after reset", {31'b0, hit[0]}, 32'h0);

    // R2 size discovery, R8 offsets
    cfg_wr(6'h0C, 4'hF, 32'hFFFF_F800);
    cfg_wr(6'h0E, 4'hF, 32'hFFFF_F800);
    cfg_rd(6'h0C); chk("R2 size mask 128K", rdata[0], 32'hFFFE_0000);
    chk("R9 norom reads 0", rdata[2], 32'h0);
    cfg_rd(6'h0E); chk("R2 size mask bridge 4K", rdata[1], 32'hFFFF_F000);
    chk("R8 ep not at 0Eh", rdata[0], 32'h0);

    // program window, R5 enable
    cfg_wr(6'h0C, 4'hF, 32'hEFFE_0001);
    cfg_wr(6'h0E, 4'hF, 32'h8000_1001);
    cfg_rd(6'h0C); chk("R5 enable reads back", rdata[0], 32'hEFFE_0001);
    cfg_rd(6'h0E); chk("R8 bridge base", rdata[1], 32'h8000_1001);

    // R6 gating by memory-space enable and strobe
    probe(1'b1, 1'b0, 32'hEFFE_0000); chk("R6 mse off no hit", {31'b0, hit[0]}, 32'h0);
    probe(1'b0, 1'b1, 32'hEFFE_0000); chk("R6 no strobe no hit", {31'b0, hit[0]}, 32'h0);
    probe(1'b1, 1'b1, 32'hEFFE_0000); chk("R10 hit same cycle", {31'b0, hit[0]}, 32'h1);
    chk("R9 norom no hit", {31'b0, hit[2]}, 32'h0);

    // R7 window edges
    probe(1'b1, 1'b1, 32'hEFFF_FFFF); chk("R7 last byte hits", {31'b0, hit[0]}, 32'h1);
    probe(1'b1, 1'b1, 32'hF000_0000); chk("R7 past end misses", {31'b0, hit[0]}, 32'h0);
    probe(1'b1, 1'b1, 32'hEFFD_FFFF); chk("R7 below base misses", {31'b0, hit[0]}, 32'h0);
    probe(1'b1, 1'b1, 32'h8000_1FFF); chk("R7 bridge last byte", {31'b0, hit[1]}, 32'h1);
    probe(1'b1, 1'b1, 32'h8000_2000); chk("R7 bridge past end", {31'b0, hit[1]}, 32'h0);

    // R3 reserved and sub-size bits ignore writes
    cfg_wr(6'h0C, 4'b0111, 32'h00FF_FFFE);
    cfg_rd(6'h0C); chk("R3 low bits stay 0", rdata[0], 32'hEFFE_0000);

    // R4 single lane write
    cfg_wr(6'h0C, 4'b1000, 32'h12AB_CDEF);
    cfg_rd(6'h0C); chk("R4 top lane only", rdata[0], 32'h12FE_0000);

    // R8 write to other offset ignored
    cfg_wr(6'h10, 4'hF, 32'hFFFF_FFFF);
    cfg_rd(6'h0C); chk("R8 foreign offset write ignored", rdata[0], 32'h12FE_0000);
    cfg_rd(6'h10); chk("R8 foreign offset reads 0", rdata[0], 32'h0);

    // R5 enable clear stops decoding
    cfg_wr(6'h0C, 4'b0001, 32'h0000_0001);
    probe(1'b1, 1'b1, 32'h12FE_0010); chk("R5 enabled hit", {31'b0, hit[0]}, 32'h1);
    cfg_wr(6'h0C, 4'b0001, 32'h0000_0000);
    probe(1'b1, 1'b1, 32'h12FE_0010); chk("R5 disabled no hit", {31'b0, hit[0]}, 32'h0);

    // R11 read with write strobe returns 0
    @(negedge clk); req = 1'b1; we = 1'b1; off = 6'h0C; be = 4'h0; #1;
    chk("R11 no read data on write", rdata[0], 32'h0);
    @(negedge clk); req = 1'b0; we = 1'b0;

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule